// File: doc/BRIEF.md
# Selectable Reference Frequency Normaliser

The block takes two telecom reference clocks, a primary and a secondary, and reduces each to a common 8 kHz frame-rate event. Both references are sampled on a fast system clock. Each one passes through a synchroniser and a falling-edge detector. Each then feeds its own divider, so both references are counted all the time. A select input chooses which reference's 8 kHz event appears on the active output.

Both references carry the same nominal rate, and one two-bit rate code selects that rate. The block captures the code only while reset is asserted. A code change made outside reset is not applied: the captured ratio stays in force, and a pending flag reports the mismatch until the next reset.

The block has no data stream, so every pin is a plain control or status signal with no handshake. A downstream consumer treats each tick as a single-cycle event strobe that cannot be stalled.

Top module: `ref_rate_norm`

## Requirements
- R1: Each reference passes through a two-flop synchroniser and a falling-edge detector. For a 1-to-0 transition on `pri_in` or `sec_in` that is set up before clock edge k, the divider advances and any resulting tick is high after edge k+2. Rising transitions never advance a divider.
- R2: The rate code sets the number of falling edges per tick: 00 gives 2430 (19.44 MHz), 01 gives 1 (8 kHz), 10 gives 193 (1.544 MHz) and 11 gives 256 (2.048 MHz).
- R3: Primary and secondary have independent dividers that count regardless of `src_sel`. A divider keeps its partial count across a change of `src_sel`.
- R4: `act_tick` carries `pri_tick` when `src_sel` is 0 and `sec_tick` when `src_sel` is 1, in the same cycle.
- R5: Every tick is exactly one clock cycle wide.
- R6: `freq_code` is captured on every clock edge at which `rst_n` is low. A change while out of reset does not alter the ratio in use.
- R7: `cfg_pending` goes high one cycle after `freq_code` differs from the captured code while out of reset. It stays high while the code is unchanged and is cleared by reset.
- R8: While in reset and right after reset, all ticks and `cfg_pending` are 0, and both dividers start from a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both references |
| rst_n | input | 1 | Synchronous active-low reset; the rate code is captured while it is low |
| pri_in | input | 1 | Primary reference, asynchronous |
| sec_in | input | 1 | Secondary reference, asynchronous |
| freq_code | input | 2 | Reference rate code |
| src_sel | input | 1 | 0 selects the primary reference, 1 selects the secondary |
| pri_tick | output | 1 | 8 kHz event strobe derived from the primary |
| sec_tick | output | 1 | 8 kHz event strobe derived from the secondary |
| act_tick | output | 1 | Event strobe of the selected reference |
| cfg_pending | output | 1 | Rate code changed without a reset |

## Verification
A tick is due on the third rising edge after a falling input is set up: two edges through the synchroniser and one through the divider's tick register. `act_tick` follows `src_sel` in the same cycle, and `cfg_pending` responds one edge after a code change. The bench drives inputs on falling clock edges and samples outputs on falling edges. The latency test probes the cycles before, at and after the due tick. The counting tests wait several idle cycles after the last edge before comparing tick totals, so no pending strobe is missed.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
  localparam int unsigned NUM_REF = 2;
  localparam int unsigned IDX_PRI = 0;
  localparam int unsigned IDX_SEC = 1;

  typedef enum logic [1:0] {
    RATE_19M44 = 2'b00,
    RATE_8K    = 2'b01,
    RATE_1M544 = 2'b10,
    RATE_2M048 = 2'b11
  } rate_code_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/rrn_edge_det.sv
module rrn_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [SYNC_STAGES:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[SYNC_STAGES-1:0], din};
  end

  // oldest stage high, next-newer stage low: a 1-to-0 transition
  assign fall = hist[SYNC_STAGES] & ~hist[SYNC_STAGES-1];
endmodule

// File: rtl/rrn_divider.sv
module rrn_divider #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] ratio,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= ratio - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= step & wrap;
      if (step) cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rrn_cfg.sv
module rrn_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_in,
  output logic [1:0] code_q,
  output logic       pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= code_in;
      pending <= 1'b0;
    end else begin
      pending <= (code_in != code_q);
    end
  end
endmodule

// File: rtl/ref_rate_norm.sv
module ref_rate_norm #(
  parameter int unsigned DIV_19M44   = 2430,
  parameter int unsigned DIV_8K      = 1,
  parameter int unsigned DIV_1M544   = 193,
  parameter int unsigned DIV_2M048   = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pri_in,
  input  logic       sec_in,
  input  logic [1:0] freq_code,
  input  logic       src_sel,
  output logic       pri_tick,
  output logic       sec_tick,
  output logic       act_tick,
  output logic       cfg_pending
);
  import rrn_pkg::*;

  localparam int unsigned MAX_DIV = max4(DIV_19M44, DIV_8K, DIV_1M544, DIV_2M048);
  localparam int unsigned CNT_W   = (MAX_DIV < 2) ? 1 : $clog2(MAX_DIV);

  logic [1:0]       code_q;
  logic [CNT_W-1:0] ratio;
  logic [NUM_REF-1:0] ref_raw, ref_fall, ref_tick;

  rrn_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_in (freq_code),
    .code_q  (code_q),
    .pending (cfg_pending)
  );

  always_comb begin
    unique case (rate_code_e'(code_q))
      RATE_19M44: ratio = CNT_W'(DIV_19M44);
      RATE_8K:    ratio = CNT_W'(DIV_8K);
      RATE_1M544: ratio = CNT_W'(DIV_1M544);
      default:    ratio = CNT_W'(DIV_2M048);
    endcase
  end

  assign ref_raw[IDX_PRI] = pri_in;
  assign ref_raw[IDX_SEC] = sec_in;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    rrn_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ref_raw[g]),
      .fall  (ref_fall[g])
    );
    rrn_divider #(.CNT_W(CNT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (ref_fall[g]),
      .ratio (ratio),
      .tick  (ref_tick[g])
    );
  end

  assign pri_tick = ref_tick[IDX_PRI];
  assign sec_tick = ref_tick[IDX_SEC];
  assign act_tick = src_sel ? ref_tick[IDX_SEC] : ref_tick[IDX_PRI];
endmodule

// File: rtl/ref_rate_norm_chk.sv
module ref_rate_norm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pri_in,
  input logic       sec_in,
  input logic [1:0] freq_code,
  input logic       src_sel,
  input logic       pri_tick,
  input logic       sec_tick,
  input logic       act_tick,
  input logic       cfg_pending
);
  AST_PRI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) pri_tick |=> !pri_tick); // R5
  AST_SEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sec_tick |=> !sec_tick); // R5
  AST_PRI_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    pri_tick |-> (!$past(pri_in, 3) && $past(pri_in, 4))); // R1
  AST_SEC_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (!$past(sec_in, 3) && $past(sec_in, 4))); // R1
  AST_ACT_FROM_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    (act_tick && !src_sel) |-> pri_tick); // R4
  AST_ACT_FROM_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (act_tick && src_sel) |-> sec_tick); // R4
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending && $stable(freq_code)) |=> cfg_pending); // R7
endmodule

bind ref_rate_norm ref_rate_norm_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pri_in      (pri_in),
  .sec_in      (sec_in),
  .freq_code   (freq_code),
  .src_sel     (src_sel),
  .pri_tick    (pri_tick),
  .sec_tick    (sec_tick),
  .act_tick    (act_tick),
  .cfg_pending (cfg_pending)
);

// File: tb/tb_ref_rate_norm.sv
`timescale 1ns/1ps
module tb_ref_rate_norm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pri_in = 1'b1, sec_in = 1'b1;
  logic [1:0] freq_code = 2'b01;
  logic src_sel = 1'b0;
  logic pri_tick, sec_tick, act_tick, cfg_pending;

  int n_chk = 0, n_bad = 0;
  int pri_cnt = 0, sec_cnt = 0, act_cnt = 0;

  always #4 clk = ~clk;

  ref_rate_norm dut (
    .clk(clk), .rst_n(rst_n), .pri_in(pri_in), .sec_in(sec_in),
    .freq_code(freq_code), .src_sel(src_sel), .pri_tick(pri_tick),
    .sec_tick(sec_tick), .act_tick(act_tick), .cfg_pending(cfg_pending)
  );

  always @(negedge clk) begin
    if (pri_tick) pri_cnt++;
    if (sec_tick) sec_cnt++;
    if (act_tick) act_cnt++;
  end

  typedef struct packed {
    logic [1:0] code;
    logic       sel;
    int         npri;
    int         nsec;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{code: 2'b01, sel: 1'b0, npri: 3,    nsec: 5},
    '{code: 2'b01, sel: 1'b1, npri: 3,    nsec: 5},
    '{code: 2'b10, sel: 1'b0, npri: 193,  nsec: 192},
    '{code: 2'b11, sel: 1'b1, npri: 255,  nsec: 512},
    '{code: 2'b00, sel: 1'b0, npri: 2430, nsec: 10}
  };

  function automatic int ratio_of(input logic [1:0] c);
    case (c)
      2'b00: return 2430;
      2'b01: return 1;
      2'b10: return 193;
      default: return 256;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] c);
    @(negedge clk);
    rst_n = 1'b0;
    freq_code = c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic falls(input bit on_sec, input int n);
    for (int i = 0; i < n; i++) begin
      if (on_sec) sec_in = 1'b0; else pri_in = 1'b0;
      repeat (2) @(negedge clk);
      if (on_sec) sec_in = 1'b1; else pri_in = 1'b1;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int bp, bs, ba;
    repeat (3) @(negedge clk);
    // R8: outputs held low in reset
    check("R8 pri_tick in reset", pri_tick, 0);
    check("R8 pending in reset", cfg_pending, 0);
    do_reset(2'b01);
    check("R8 act_tick after reset", act_tick, 0);
    check("R8 pending after reset", cfg_pending, 0);

    // vector table: R2 ratios, R3 independent counting, R4 selection
    foreach (VECS[v]) begin
      do_reset(VECS[v].code);
      src_sel = VECS[v].sel;
      bp = pri_cnt; bs = sec_cnt; ba = act_cnt;
      falls(1'b0, VECS[v].npri);
      falls(1'b1, VECS[v].nsec);
      check("R2 pri tick count", pri_cnt - bp, VECS[v].npri / ratio_of(VECS[v].code));
      check("R3 sec tick count", sec_cnt - bs, VECS[v].nsec / ratio_of(VECS[v].code));
      check("R4 act tick count", act_cnt - ba,
            VECS[v].sel ? VECS[v].nsec / ratio_of(VECS[v].code)
                        : VECS[v].npri / ratio_of(VECS[v].code));
    end

    // R1/R5: latency of three edges and a single-cycle strobe
    do_reset(2'b01);
    src_sel = 1'b0;
    pri_in = 1'b0;
    @(negedge clk); check("R1 no tick after 1 edge", pri_tick, 0);
    @(negedge clk); check("R1 no tick after 2 edges", pri_tick, 0);
    @(negedge clk); check("R1 tick after 3 edges", pri_tick, 1);
    check("R4 act follows pri", act_tick, 1);
    @(negedge clk); check("R5 tick one cycle", pri_tick, 0);
    bp = pri_cnt;
    pri_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 rising edge ignored", pri_cnt - bp, 0);

    // R6/R7: code change without reset is flagged but not applied
    freq_code = 2'b11;
    @(negedge clk); check("R7 pending raised", cfg_pending, 1);
    bp = pri_cnt;
    falls(1'b0, 1);
    check("R6 old ratio kept", pri_cnt - bp, 1);
    check("R7 pending held", cfg_pending, 1);
    do_reset(2'b11);
    check("R7 pending cleared by reset", cfg_pending, 0);
    bp = pri_cnt;
    falls(1'b0, 1);
    check("R6 new ratio after reset", pri_cnt - bp, 0);
    falls(1'b0, 255);
    check("R6 256 edges give one tick", pri_cnt - bp, 1);

    // R3: partial count survives a source switch
    do_reset(2'b10);
    src_sel = 1'b0;
    ba = act_cnt;
    falls(1'b1, 100);
    check("R4 unselected sec hidden", act_cnt - ba, 0);
    src_sel = 1'b1;
    falls(1'b1, 93);
    check("R3 sec count kept across switch", act_cnt - ba, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule